// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block gathers 32 interrupt request lines, gates them through a software-written enable mask and sorts each enabled line into one of two classes, fast or normal, using a per-line class bit. Fast-class lines drive a fast interrupt output and can be read back through a read-only fast status word. Normal-class lines drive a normal interrupt output.

Sixteen vector slots let software point a normal-class source at its own handler. Each slot pairs a 5-bit source number with a 32-bit handler address. When the service routine reads the vector word, it receives the handler address of the highest-priority slot that is responding. If no slot responds, it receives a programmable fallback address. Slot 0 has the highest priority.

The block sits on a simple 32-bit register bus. Writes take effect at the clock edge. Read data appears one cycle after the read is presented.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After synchronous reset, every writable register is zero: enable, class, fallback address, slot addresses and slot controls. Both interrupt outputs are low and `bus_rdata` is zero.
- R2: The fast status word at offset 0x004 has bit n set when line n is asserted, enabled (enable word at 0x010, 1 = enabled) and classed fast (class word at 0x00C, 1 = fast). `fast_irq_o` is high exactly when that word is non-zero.
- R3: `norm_irq_o` is high exactly when some line is asserted, enabled and classed normal.
- R4: A read of the vector word at offset 0x030 returns the handler address of the lowest-numbered responding slot. Slot k has its address at 0x100+4k and its control at 0x200+4k.
- R5: A slot responds only when its control bit 5 is set and the source named in control bits 4:0 is asserted, enabled and classed normal. A fast-classed or masked source never selects a slot.
- R6: When no slot responds, the vector read returns the fallback address held at offset 0x034.
- R7: A line whose slot is disabled, or that has no slot at all, still raises `norm_irq_o` and is served through the fallback address.
- R8: If two enabled slots name the same source, the lower-numbered slot supplies the address.
- R9: A slot control reads back only bits 5:0; all higher bits read as zero.
- R10: `bus_rdata` shows the value addressed by a read in the cycle after the read is presented. It holds its previous value until that edge.
- R11: Writes to reserved offsets and to the read-only words (0x004, 0x030) change no register. Reads of reserved offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_lines | input | 32 | Interrupt request lines, active high |
| fast_irq_o | output | 1 | Fast interrupt request |
| norm_irq_o | output | 1 | Normal interrupt request |

## Verification
Slots are set up so that one source is mapped twice, one slot names a fast-classed source, one slot is disabled and one source is masked. Line patterns are then applied one at a time:
- No lines asserted.
- A single line that owns a slot.
- Two mapped lines together, which tests priority order.
- The duplicated source, which tests the lower-slot rule.
- A fast-classed source alone, which must not pick a slot.
- The disabled-slot source, which must fall back yet still raise the normal output.
- The masked source, which must do nothing.
- A mix of fast and normal lines.

For each pattern, the vector read, the fast status word and both outputs are compared against values the bench predicts. Directed tests then cover reset values, control-word readback width, ignored writes and the one-cycle read latency.

// File: rtl/vic_pkg.sv
package vic_pkg;

    localparam int NUM_SRC  = 32;
    localparam int NUM_SLOT = 16;
    localparam int SRC_W    = $clog2(NUM_SRC);
    localparam int SLOT_W   = $clog2(NUM_SLOT);
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 12;
    localparam int CTL_W    = SRC_W + 1;

    localparam logic [ADDR_W-1:0] OFF_FSTAT = 12'h004;
    localparam logic [ADDR_W-1:0] OFF_CLASS = 12'h00C;
    localparam logic [ADDR_W-1:0] OFF_EN    = 12'h010;
    localparam logic [ADDR_W-1:0] OFF_VEC   = 12'h030;
    localparam logic [ADDR_W-1:0] OFF_DEF   = 12'h034;

    localparam logic [ADDR_W-SLOT_W-3:0] PAGE_SLOT_ADDR = 6'h04;
    localparam logic [ADDR_W-SLOT_W-3:0] PAGE_SLOT_CTL  = 6'h08;

    typedef struct packed {
        logic             en;
        logic [SRC_W-1:0] src;
    } slot_ctl_t;

    typedef struct packed {
        logic              sel;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic logic in_page(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-SLOT_W-3:0] page);
        return (a[ADDR_W-1:SLOT_W+2] == page) && (a[1:0] == 2'b00);
    endfunction

    function automatic logic [SLOT_W-1:0] slot_of(input logic [ADDR_W-1:0] a);
        return a[SLOT_W+1:2];
    endfunction

endpackage

// File: rtl/vic_prio.sv
module vic_prio
    import vic_pkg::*;
(
    input  logic [NUM_SRC-1:0]             norm_act,
    input  slot_ctl_t [NUM_SLOT-1:0]       ctl,
    output logic                           hit,
    output logic [SLOT_W-1:0]              hit_idx
);

    logic [NUM_SLOT-1:0] resp;

    for (genvar g = 0; g < NUM_SLOT; g++) begin : g_resp
        assign resp[g] = ctl[g].en & norm_act[ctl[g].src];
    end

    // Scan from lowest priority upward so the lowest index wins.
    always_comb begin
        hit_idx = '0;
        for (int i = NUM_SLOT - 1; i >= 0; i--) begin
            if (resp[i]) hit_idx = SLOT_W'(i);
        end
    end

    assign hit = |resp;

endmodule

// File: rtl/vic_regs.sv
module vic_regs
    import vic_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  bus_req_t                 req,
    input  logic [NUM_SRC-1:0]       fast_stat,
    input  logic                     hit,
    input  logic [SLOT_W-1:0]        hit_idx,
    output logic [NUM_SRC-1:0]       en_q,
    output logic [NUM_SRC-1:0]       class_q,
    output logic [DATA_W-1:0]        def_q,
    output slot_ctl_t [NUM_SLOT-1:0] ctl_q,
    output logic [DATA_W-1:0]        rdata
);

    logic [DATA_W-1:0] addr_q [NUM_SLOT];
    logic              wr_en;
    logic              rd_en;
    logic [SLOT_W-1:0] idx;
    logic              is_addr;
    logic              is_ctl;
    logic [DATA_W-1:0] vec_val;
    logic [DATA_W-1:0] rd_next;

    assign wr_en   = req.sel & req.wr;
    assign rd_en   = req.sel & ~req.wr;
    assign idx     = slot_of(req.addr);
    assign is_addr = in_page(req.addr, PAGE_SLOT_ADDR);
    assign is_ctl  = in_page(req.addr, PAGE_SLOT_CTL);
    assign vec_val = hit ? addr_q[hit_idx] : def_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '0;
            class_q <= '0;
            def_q   <= '0;
        end else if (wr_en) begin
            if (req.addr == OFF_EN)    en_q    <= req.wdata;
            if (req.addr == OFF_CLASS) class_q <= req.wdata;
            if (req.addr == OFF_DEF)   def_q   <= req.wdata;
        end
    end

    for (genvar g = 0; g < NUM_SLOT; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                addr_q[g] <= '0;
                ctl_q[g]  <= '0;
            end else if (wr_en && idx == SLOT_W'(g)) begin
                if (is_addr) addr_q[g] <= req.wdata;
                if (is_ctl)  ctl_q[g]  <= req.wdata[CTL_W-1:0];
            end
        end
    end

    always_comb begin
        rd_next = '0;
        if (req.addr == OFF_FSTAT)      rd_next = fast_stat;
        else if (req.addr == OFF_CLASS) rd_next = class_q;
        else if (req.addr == OFF_EN)    rd_next = en_q;
        else if (req.addr == OFF_VEC)   rd_next = vec_val;
        else if (req.addr == OFF_DEF)   rd_next = def_q;
        else if (is_addr)               rd_next = addr_q[idx];
        else if (is_ctl)                rd_next = {{(DATA_W-CTL_W){1'b0}}, ctl_q[idx]};
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_next;
    end

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import vic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       irq_lines,
    output logic              fast_irq_o,
    output logic              norm_irq_o
);

    bus_req_t                 req;
    logic [NUM_SRC-1:0]       en_q;
    logic [NUM_SRC-1:0]       class_q;
    logic [DATA_W-1:0]        def_vec;
    slot_ctl_t [NUM_SLOT-1:0] ctl_q;
    logic [NUM_SRC-1:0]       fast_stat;
    logic [NUM_SRC-1:0]       norm_act;
    logic                     prio_hit;
    logic [SLOT_W-1:0]        prio_idx;

    assign req = '{sel: bus_sel, wr: bus_wr, addr: bus_addr, wdata: bus_wdata};

    assign fast_stat  = irq_lines & en_q & class_q;
    assign norm_act   = irq_lines & en_q & ~class_q;
    assign fast_irq_o = |fast_stat;
    assign norm_irq_o = |norm_act;

    vic_prio u_prio (
        .norm_act (norm_act),
        .ctl      (ctl_q),
        .hit      (prio_hit),
        .hit_idx  (prio_idx)
    );

    vic_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .fast_stat (fast_stat),
        .hit       (prio_hit),
        .hit_idx   (prio_idx),
        .en_q      (en_q),
        .class_q   (class_q),
        .def_q     (def_vec),
        .ctl_q     (ctl_q),
        .rdata     (bus_rdata)
    );

endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic [11:0] bus_addr,
    input logic [31:0] bus_rdata,
    input logic [31:0] irq_lines,
    input logic        fast_irq_o,
    input logic        norm_irq_o,
    input logic        hit,
    input logic [31:0] def_vec
);

    // R1: reset clears the read data register
    p_rst_rdata_r1: assert property (@(posedge clk) rst |=> bus_rdata == 32'h0);

    // R2 / R3: no asserted line, no request
    p_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (irq_lines == 32'h0) |-> (!fast_irq_o && !norm_irq_o));

    p_fast_src_r2: assert property (@(posedge clk) disable iff (rst)
        fast_irq_o |-> (irq_lines != 32'h0));

    // R5 / R7: a responding slot implies the normal request is up
    p_slot_norm_r5: assert property (@(posedge clk) disable iff (rst)
        hit |-> norm_irq_o);

    // R10: fallback read appears one cycle later
    p_def_latency_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && bus_addr == 12'h034) |=> bus_rdata == $past(def_vec));

    // R6: vector read with no responder yields the fallback address
    p_vec_default_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && bus_addr == 12'h030 && !hit) |=> bus_rdata == $past(def_vec));

endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .irq_lines  (irq_lines),
    .fast_irq_o (fast_irq_o),
    .norm_irq_o (norm_irq_o),
    .hit        (prio_hit),
    .def_vec    (def_vec)
);

// File: tb/vec_irq_ctrl_test.sv
module vec_irq_ctrl_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_sel;
    logic        bus_wr;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [31:0] irq_lines;
    logic        fast_irq_o;
    logic        norm_irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    localparam logic [31:0] EN_MASK  = ~(32'h1 << 30);
    localparam logic [31:0] FAST_SEL = 32'h0000_00F0;
    localparam logic [31:0] DEF_ADDR = 32'hDEF0_0000;

    typedef struct packed {
        logic [31:0] lines;
        logic [31:0] vec;
        logic        norm;
        logic        fast;
    } tv_t;

    // slot addresses are 0x1000 + 0x10*k
    localparam tv_t TV [0:8] = '{
        '{32'h0000_0000, DEF_ADDR,      1'b0, 1'b0},  // idle, R6
        '{32'h0010_0000, 32'h0000_1050, 1'b1, 1'b0},  // src20 -> slot5, R4
        '{32'h0010_0200, 32'h0000_1000, 1'b1, 1'b0},  // src9+src20 -> slot0, R4
        '{32'h0000_0008, 32'h0000_1010, 1'b1, 1'b0},  // src3 dup slots1/2, R8
        '{32'h0000_0020, DEF_ADDR,      1'b0, 1'b1},  // src5 fast, R5
        '{32'h0000_1000, DEF_ADDR,      1'b1, 1'b0},  // src12 slot off, R7
        '{32'h4000_0000, DEF_ADDR,      1'b0, 1'b0},  // src30 masked, R5
        '{32'h0010_0028, 32'h0000_1010, 1'b1, 1'b1},  // mix, R2/R4
        '{32'h0000_0001, DEF_ADDR,      1'b1, 1'b0}   // src0 no enabled slot, R7
    };

    vec_irq_ctrl uut (
        .clk        (clk),
        .rst        (rst),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq_lines  (irq_lines),
        .fast_irq_o (fast_irq_o),
        .norm_irq_o (norm_irq_o)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(posedge clk);
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        rst = 1'b1; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        irq_lines = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state
        #1;
        check("R1 rdata", bus_rdata, 32'h0);
        check("R1 fast_irq_o", {31'h0, fast_irq_o}, 32'h0);
        check("R1 norm_irq_o", {31'h0, norm_irq_o}, 32'h0);
        bus_read(12'h034, rd); check("R1 fallback", rd, 32'h0);
        bus_read(12'h010, rd); check("R1 enable", rd, 32'h0);
        bus_read(12'h200, rd); check("R1 slot0 ctl", rd, 32'h0);
        bus_read(12'h13C, rd); check("R1 slot15 addr", rd, 32'h0);
        bus_read(12'h030, rd); check("R1 vector", rd, 32'h0);
        irq_lines = 32'h0;

        // configuration
        bus_write(12'h010, EN_MASK);
        bus_write(12'h00C, FAST_SEL);
        bus_write(12'h034, DEF_ADDR);
        for (int k = 0; k < 16; k++)
            bus_write(12'(12'h100 + 4 * k), 32'h1000 + 32'(16 * k));
        bus_write(12'h200, 32'h20 | 9);   // slot0 src9
        bus_write(12'h204, 32'h20 | 3);   // slot1 src3
        bus_write(12'h208, 32'h20 | 3);   // slot2 src3 (duplicate)
        bus_write(12'h20C, 32'h20 | 5);   // slot3 src5 (fast source)
        bus_write(12'h210, 32'h00 | 12);  // slot4 src12 disabled
        bus_write(12'h214, 32'h20 | 20);  // slot5 src20
        bus_write(12'h218, 32'h20 | 30);  // slot6 src30 (masked source)

        // vector table
        for (int t = 0; t < 9; t++) begin
            @(negedge clk) irq_lines = TV[t].lines;
            #1;
            check("R3 norm_irq_o", {31'h0, norm_irq_o}, {31'h0, TV[t].norm});
            check("R2 fast_irq_o", {31'h0, fast_irq_o}, {31'h0, TV[t].fast});
            bus_read(12'h030, rd);
            check("R4/R5/R6/R7/R8 vector", rd, TV[t].vec);
            bus_read(12'h004, rd);
            check("R2 fast status", rd, TV[t].lines & EN_MASK & FAST_SEL);
        end
        irq_lines = 32'h0;

        // R9: control readback width
        bus_write(12'h220, 32'hFFFF_FFFF);
        bus_read(12'h220, rd); check("R9 slot8 ctl", rd, 32'h0000_003F);

        // R11: ignored writes and reserved reads
        bus_write(12'h050, 32'hA5A5_A5A5);
        bus_read(12'h050, rd); check("R11 reserved read", rd, 32'h0);
        bus_write(12'h004, 32'hFFFF_FFFF);
        bus_read(12'h004, rd); check("R11 fast status write", rd, 32'h0);
        bus_write(12'h030, 32'h1234_5678);
        bus_read(12'h034, rd); check("R11 fallback kept", rd, DEF_ADDR);
        bus_read(12'h030, rd); check("R11 vector write", rd, DEF_ADDR);
        bus_read(12'h100, rd); check("R11 slot0 addr kept", rd, 32'h0000_1000);
        bus_read(12'h010, rd); check("R11 enable kept", rd, EN_MASK);

        // R10: latency, back-to-back reads
        @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 12'h034;
        @(negedge clk); bus_addr = 12'h114;
        #1 check("R10 before edge", bus_rdata, DEF_ADDR);
        @(posedge clk); #1 check("R10 after edge", bus_rdata, 32'h0000_1050);
        @(negedge clk); bus_sel = 1'b0;
        #1 check("R10 hold", bus_rdata, 32'h0000_1050);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule